// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a legacy I/O controller on an 8-bit host I/O bus. It uses two byte-wide ports. The key/index port sits at a base address chosen by a strap pin, and the data port sits at the next address. After reset the block is locked. A host opens it by writing the opening key twice in a row to the key/index port, and closes it with a closing key. While the block is open, every other write to the key/index port selects a register index. The data port then reads or writes the selected register.

A small set of global registers holds the chip identity, the revision, a per-device power enable field and a device selector. The device selector picks one of nine per-device register banks, and every index from 0x30 upward goes to the selected bank. Each bank holds an activate bit, a 16-bit I/O base and a primary interrupt number. Only some devices have the extra registers: a secondary interrupt for the keyboard, DMA channels for the floppy and parallel devices, and mode and option bytes for the floppy. All bank contents drive output pins, so the surrounding peripherals can decode their own settings.

Top module: `cfgk_keyport`

## Requirements
- R1: The block opens only after two consecutive writes of 0x55 to the key/index port. Any other value written to that port between them restarts the count, so the sequence 0x55, 0x12, 0x55 leaves the block locked. `cfg_mode` is 1 while the block is open.
- R2: While the block is open, writing 0xAA to the key/index port locks it again.
- R3: While the block is locked, writes to the data port are ignored and reads of the data port return 0xFF.
- R4: While the block is open, a write of any value other than 0xAA to the key/index port sets the index. A data-port read strobe in cycle N places the addressed register's value on `io_rdata` after the clock edge that ends cycle N. `io_rdata` holds that value until the next read.
- R5: Index 0x20 reads 0x02 and index 0x21 reads the revision (0x01 by default). Both registers are read-only.
- R6: Index 0x07 is the device selector. It stores bits 3:0 of the written value, and bits 7:4 read as 0. Devices are numbered 0 floppy, 1 and 2 disk, 3 parallel, 4 and 5 serial, 6 clock, 7 keyboard and 8 auxiliary.
- R7: In the selected bank, bit 0 of index 0x30 drives `dev_act[n]`. Indices 0x60 and 0x61 are the high and low bytes of `dev_base[16n+15:16n]`, and index 0x70 drives `dev_irq[8n+7:8n]`. All of these read back what was written, except that 0x30 reads back only bit 0.
- R8: Index 0x72 exists only in device 7 and drives `kbd_irq2`. Index 0x74 exists only in devices 0 and 3 and drives `dev_dma[8n+7:8n]`. In any other bank these indices read 0 and ignore writes.
- R9: Indices 0x90 (mode) and 0x91 (option) exist only in device 0 and drive `fdc_mode` and `fdc_option`. `fdc_burst` is 1 exactly when mode bits 3:1 are all set.
- R10: Index 0x22 is the power enable field. Bits 5:0 are writable and drive `pwr_en`, and bits 7:6 read 0.
- R11: Unimplemented indices, and any bank index while the selector holds 9 or more, read 0x00 and ignore writes.
- R12: With `strap_alt` at 0 the ports sit at 0x3F0 and 0x3F1, and with it at 1 they sit at 0x370 and 0x371. Accesses to any other address have no effect.
- R13: After reset the block is locked, every register is 0 (selector, activate bits, bases, interrupts, DMA, mode, option and power), and `io_rdata` is 0xFF.
- R14: A data-port read and a data-port write in the same cycle return the register's old value and store the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base address select: 0 selects 0x3F0, 1 selects 0x370 |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while the block is open |
| dev_act | output | NDEV | Activate bit for each device |
| dev_base | output | NDEV*16 | I/O base for each device |
| dev_irq | output | NDEV*8 | Primary interrupt for each device |
| dev_dma | output | NDEV*8 | DMA channel for each device (0 where the device has none) |
| kbd_irq2 | output | 8 | Keyboard secondary interrupt |
| fdc_mode | output | 8 | Floppy mode byte |
| fdc_option | output | 8 | Floppy option byte |
| fdc_burst | output | 1 | Floppy burst enable, decoded from the mode byte |
| pwr_en | output | PWR_W | Power enable bit for each device |

## Verification
A data-port read and a data-port write can fall in the same cycle. This happens when a host performs the read-modify-write that the floppy mode register needs. The bench provokes this case by driving both strobes in one cycle on the data port, once on the activate register and once on the mode register. It expects `io_rdata` to carry the value from before the write. A following plain read must show the new value, and the decoded output pins must follow it.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IX_SEL   = 8'h07;
  localparam logic [7:0] IX_ID    = 8'h20;
  localparam logic [7:0] IX_REV   = 8'h21;
  localparam logic [7:0] IX_PWR   = 8'h22;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_BHI   = 8'h60;
  localparam logic [7:0] IX_BLO   = 8'h61;
  localparam logic [7:0] IX_IRQ   = 8'h70;
  localparam logic [7:0] IX_IRQ2  = 8'h72;
  localparam logic [7:0] IX_DMA   = 8'h74;
  localparam logic [7:0] IX_FMODE = 8'h90;
  localparam logic [7:0] IX_FOPT  = 8'h91;

  localparam int DEV_FDD = 0;
  localparam int DEV_PAR = 3;
  localparam int DEV_KBD = 7;

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;
endpackage

// File: rtl/cfgk_keyfsm.sv
module cfgk_keyfsm
  import cfgk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic [7:0] idx_o
);
  lock_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_SHUT;
      idx_o   <= 8'h00;
    end else if (key_wr) begin
      case (state_q)
        LK_SHUT: if (wdata == KEY_OPEN) state_q <= LK_HALF;
        LK_HALF: state_q <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
        LK_OPEN: begin
          if (wdata == KEY_CLOSE) state_q <= LK_SHUT;
          else                    idx_o   <= wdata;
        end
        default: state_q <= LK_SHUT;
      endcase
    end
  end

  assign open_o = (state_q == LK_OPEN);

  AST_OPEN_NEEDS_KEYS: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(key_wr && wdata == KEY_OPEN && state_q == LK_HALF)); // R1
  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (rst)
    (open_o && key_wr && wdata == KEY_CLOSE) |=> !open_o); // R2
endmodule

// File: rtl/cfgk_bank.sv
module cfgk_bank
  import cfgk_pkg::*;
#(
  parameter int HAS_IRQ2 = 0,
  parameter int HAS_DMA  = 0,
  parameter int HAS_FDD  = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        act,
  output logic [15:0] base,
  output logic [7:0]  irq,
  output logic [7:0]  irq2,
  output logic [7:0]  dma,
  output logic [7:0]  mode,
  output logic [7:0]  option,
  output logic [7:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      base   <= 16'h0000;
      irq    <= 8'h00;
      irq2   <= 8'h00;
      dma    <= 8'h00;
      mode   <= 8'h00;
      option <= 8'h00;
    end else if (wr_en) begin
      case (idx)
        IX_ACT:   act        <= wdata[0];
        IX_BHI:   base[15:8] <= wdata;
        IX_BLO:   base[7:0]  <= wdata;
        IX_IRQ:   irq        <= wdata;
        IX_IRQ2:  if (HAS_IRQ2 != 0) irq2   <= wdata;
        IX_DMA:   if (HAS_DMA  != 0) dma    <= wdata;
        IX_FMODE: if (HAS_FDD  != 0) mode   <= wdata;
        IX_FOPT:  if (HAS_FDD  != 0) option <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_ACT:   rd_data = {7'b0, act};
      IX_BHI:   rd_data = base[15:8];
      IX_BLO:   rd_data = base[7:0];
      IX_IRQ:   rd_data = irq;
      IX_IRQ2:  rd_data = irq2;
      IX_DMA:   rd_data = dma;
      IX_FMODE: rd_data = mode;
      IX_FOPT:  rd_data = option;
      default:  rd_data = 8'h00;
    endcase
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({act, base, irq, irq2, dma, mode, option})); // R3
endmodule

// File: rtl/cfgk_keyport.sv
module cfgk_keyport
  import cfgk_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              NDEV     = 9,
  parameter int              PWR_W    = 6,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h03F0,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h0370,
  parameter logic [7:0]      DEV_ID   = 8'h02,
  parameter logic [7:0]      DEV_REV  = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_alt,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic                cfg_mode,
  output logic [NDEV-1:0]     dev_act,
  output logic [NDEV*16-1:0]  dev_base,
  output logic [NDEV*8-1:0]   dev_irq,
  output logic [NDEV*8-1:0]   dev_dma,
  output logic [7:0]          kbd_irq2,
  output logic [7:0]          fdc_mode,
  output logic [7:0]          fdc_option,
  output logic                fdc_burst,
  output logic [PWR_W-1:0]    pwr_en
);
  localparam int SEL_W = $clog2(NDEV);

  logic [ADDR_W-1:0] base_a;
  logic              key_wr, dat_wr, dat_rd, cfg_wr;
  logic [7:0]        idx;
  logic [SEL_W-1:0]  sel_q;
  logic [PWR_W-1:0]  pwr_q;
  logic [NDEV-1:0]   bk_hit;
  logic [7:0]        bk_rd   [NDEV];
  logic [7:0]        irq2_v  [NDEV];
  logic [7:0]        mode_v  [NDEV];
  logic [7:0]        opt_v   [NDEV];
  logic [7:0]        bank_pick, rd_mux;

  // Port decode
  assign base_a = strap_alt ? BASE_ALT : BASE_PRI;
  assign key_wr = io_wr && (io_addr == base_a);
  assign dat_wr = io_wr && (io_addr == base_a + ADDR_W'(1));
  assign dat_rd = io_rd && (io_addr == base_a + ADDR_W'(1));

  cfgk_keyfsm u_keyfsm (
    .clk    (clk),
    .rst    (rst),
    .key_wr (key_wr),
    .wdata  (io_wdata),
    .open_o (cfg_mode),
    .idx_o  (idx)
  );

  assign cfg_wr = cfg_mode && dat_wr;

  // Global registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      pwr_q <= '0;
    end else if (cfg_wr) begin
      case (idx)
        IX_SEL:  sel_q <= io_wdata[SEL_W-1:0];
        IX_PWR:  pwr_q <= io_wdata[PWR_W-1:0];
        default: ;
      endcase
    end
  end
  assign pwr_en = pwr_q;

  // Per-device banks
  for (genvar g = 0; g < NDEV; g++) begin : g_bank
    assign bk_hit[g] = (sel_q == SEL_W'(g));
    cfgk_bank #(
      .HAS_IRQ2 ((g == DEV_KBD) ? 1 : 0),
      .HAS_DMA  ((g == DEV_FDD || g == DEV_PAR) ? 1 : 0),
      .HAS_FDD  ((g == DEV_FDD) ? 1 : 0)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr && bk_hit[g]),
      .idx     (idx),
      .wdata   (io_wdata),
      .act     (dev_act[g]),
      .base    (dev_base[g*16 +: 16]),
      .irq     (dev_irq[g*8 +: 8]),
      .irq2    (irq2_v[g]),
      .dma     (dev_dma[g*8 +: 8]),
      .mode    (mode_v[g]),
      .option  (opt_v[g]),
      .rd_data (bk_rd[g])
    );
  end

  // Registers missing from a bank stay zero, so an OR merges the single live copy
  always_comb begin
    kbd_irq2   = 8'h00;
    fdc_mode   = 8'h00;
    fdc_option = 8'h00;
    bank_pick  = 8'h00;
    for (int i = 0; i < NDEV; i++) begin
      kbd_irq2   = kbd_irq2   | irq2_v[i];
      fdc_mode   = fdc_mode   | mode_v[i];
      fdc_option = fdc_option | opt_v[i];
      if (bk_hit[i]) bank_pick = bk_rd[i];
    end
  end

  assign fdc_burst = &fdc_mode[3:1];

  // Read mux
  always_comb begin
    case (idx)
      IX_SEL:  rd_mux = {{(8-SEL_W){1'b0}}, sel_q};
      IX_ID:   rd_mux = DEV_ID;
      IX_REV:  rd_mux = DEV_REV;
      IX_PWR:  rd_mux = {{(8-PWR_W){1'b0}}, pwr_q};
      default: rd_mux = (idx >= IX_ACT) ? bank_pick : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         io_rdata <= 8'hFF;
    else if (dat_rd) io_rdata <= cfg_mode ? rd_mux : 8'hFF;
  end

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && dat_rd) |=> (io_rdata == 8'hFF)); // R3
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(dev_act) && $stable(dev_base) && $stable(pwr_en))); // R3
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && dat_rd && idx == IX_ID) |=> (io_rdata == DEV_ID)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dat_rd |=> $stable(io_rdata)); // R4
endmodule

// File: tb/tb_cfgk_keyport.sv
module tb_cfgk_keyport;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strap_alt = 1'b0;
  logic [15:0]       io_addr = 16'h0;
  logic              io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]        io_wdata = 8'h0;
  logic [7:0]        io_rdata;
  logic              cfg_mode;
  logic [NDEV-1:0]   dev_act;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV*8-1:0] dev_irq, dev_dma;
  logic [7:0]        kbd_irq2, fdc_mode, fdc_option;
  logic              fdc_burst;
  logic [5:0]        pwr_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgk_keyport dut (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_mode(cfg_mode), .dev_act(dev_act), .dev_base(dev_base),
    .dev_irq(dev_irq), .dev_dma(dev_dma), .kbd_irq2(kbd_irq2),
    .fdc_mode(fdc_mode), .fdc_option(fdc_option), .fdc_burst(fdc_burst),
    .pwr_en(pwr_en)
  );

  localparam logic [15:0] KP = 16'h03F0;
  localparam logic [15:0] DP = 16'h03F1;

  // Vector: {op[1:0], req[5:0], data[7:0]}; op 0 = key/index write, 1 = data write, 2 = data read and compare
  localparam int NV = 36;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 6'd1,  8'h55}, {2'd0, 6'd1,  8'h55},                       // R1 open
    {2'd0, 6'd6,  8'h07}, {2'd1, 6'd6,  8'h04},                       // R6 select device 4
    {2'd0, 6'd7,  8'h60}, {2'd1, 6'd7,  8'h03},                       // R7 base high
    {2'd0, 6'd7,  8'h61}, {2'd1, 6'd7,  8'hF8},                       // R7 base low
    {2'd0, 6'd7,  8'h70}, {2'd1, 6'd7,  8'h04},                       // R7 irq
    {2'd0, 6'd7,  8'h30}, {2'd1, 6'd7,  8'h01},                       // R7 activate
    {2'd0, 6'd7,  8'h60}, {2'd2, 6'd7,  8'h03},                       // R7 readback
    {2'd0, 6'd7,  8'h61}, {2'd2, 6'd7,  8'hF8},
    {2'd0, 6'd7,  8'h70}, {2'd2, 6'd7,  8'h04},
    {2'd0, 6'd7,  8'h30}, {2'd2, 6'd7,  8'h01},
    {2'd0, 6'd6,  8'h07}, {2'd2, 6'd6,  8'h04},                       // R6 selector readback
    {2'd0, 6'd5,  8'h20}, {2'd2, 6'd5,  8'h02},                       // R5 identity
    {2'd0, 6'd5,  8'h21}, {2'd2, 6'd5,  8'h01},                       // R5 revision
    {2'd0, 6'd10, 8'h22}, {2'd1, 6'd10, 8'hFF}, {2'd2, 6'd10, 8'h3F}, // R10 power
    {2'd0, 6'd8,  8'h72}, {2'd1, 6'd8,  8'h0C}, {2'd2, 6'd8,  8'h00}, // R8 no irq2 in device 4
    {2'd0, 6'd8,  8'h74}, {2'd1, 6'd8,  8'h02}, {2'd2, 6'd8,  8'h00}, // R8 no DMA in device 4
    {2'd0, 6'd11, 8'h31}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic rw(input logic [15:0] a, input logic [7:0] d, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_rd = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    v = io_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R13: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R13 reset state
    chk("R13 cfg_mode", cfg_mode, 0);
    chk("R13 dev_act", dev_act, 0);
    chk("R13 dev_base", dev_base[63:0], 0);
    chk("R13 pwr_en", pwr_en, 0);
    chk("R13 io_rdata", io_rdata, 8'hFF);
    // R3 locked read
    rd(DP, v); chk("R3 locked read", v, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][15:14])
        2'd0: wr(KP, VEC[i][7:0]);
        2'd1: wr(DP, VEC[i][7:0]);
        default: begin
          rd(DP, v);
          chk($sformatf("R%0d vector %0d", VEC[i][13:8], i), v, VEC[i][7:0]);
        end
      endcase
    end
    rd(DP, v); chk("R11 unimplemented bank index", v, 8'h00);
    chk("R7 dev_act pin", dev_act[4], 1);
    chk("R7 dev_base pin", dev_base[4*16 +: 16], 16'h03F8);
    chk("R7 dev_irq pin", dev_irq[4*8 +: 8], 8'h04);
    chk("R10 pwr_en pin", pwr_en, 6'h3F);
    chk("R8 kbd_irq2 untouched", kbd_irq2, 0);

    // R5 read-only identity
    wr(KP, 8'h20); wr(DP, 8'h77); rd(DP, v); chk("R5 id read-only", v, 8'h02);
    // R11 unimplemented global index
    wr(KP, 8'h23); wr(DP, 8'h5A); rd(DP, v); chk("R11 global hole", v, 8'h00);

    // R14 same-cycle read and write on activate of device 4
    wr(KP, 8'h30);
    rw(DP, 8'h00, v); chk("R14 old value returned", v, 8'h01);
    chk("R14 new value stored", dev_act[4], 0);
    rd(DP, v); chk("R14 follow-up read", v, 8'h00);
    wr(DP, 8'h01);

    // R2 / R3 lock, then data write ignored
    wr(KP, 8'hAA); chk("R2 closed", cfg_mode, 0);
    wr(DP, 8'h00); chk("R3 write ignored", dev_act[4], 1);
    rd(DP, v); chk("R3 locked read after close", v, 8'hFF);

    // R1 interrupted key sequence
    wr(KP, 8'h55); wr(KP, 8'h12); wr(KP, 8'h55);
    chk("R1 interrupted stays locked", cfg_mode, 0);
    wr(KP, 8'h55); chk("R1 reopened", cfg_mode, 1);

    // R6 selector keeps only low nibble
    wr(KP, 8'h07); wr(DP, 8'hF5); rd(DP, v); chk("R6 selector width", v, 8'h05);

    // R9 floppy bank with read-modify-write of mode
    wr(DP, 8'h00);
    wr(KP, 8'h90); wr(DP, 8'h02);
    chk("R9 burst off", fdc_burst, 0);
    rw(DP, 8'h0E, v); chk("R14 mode old value", v, 8'h02);
    chk("R9 burst on", fdc_burst, 1);
    chk("R9 mode pin", fdc_mode, 8'h0E);
    wr(KP, 8'h91); wr(DP, 8'h5C); rd(DP, v); chk("R9 option read", v, 8'h5C);
    chk("R9 option pin", fdc_option, 8'h5C);
    wr(KP, 8'h74); wr(DP, 8'h02); chk("R8 floppy DMA pin", dev_dma[7:0], 8'h02);

    // R8 keyboard irq2, R9 mode absent in parallel bank
    wr(KP, 8'h07); wr(DP, 8'h07);
    wr(KP, 8'h72); wr(DP, 8'h0C); chk("R8 kbd_irq2 pin", kbd_irq2, 8'h0C);
    wr(KP, 8'h07); wr(DP, 8'h03);
    wr(KP, 8'h90); wr(DP, 8'hFF); rd(DP, v); chk("R9 mode absent in parallel", v, 8'h00);
    chk("R9 floppy mode untouched", fdc_mode, 8'h0E);
    wr(KP, 8'h74); wr(DP, 8'h03); rd(DP, v); chk("R8 parallel DMA", v, 8'h03);

    // R11 selector beyond last device
    wr(KP, 8'h07); wr(DP, 8'h09);
    wr(KP, 8'h30); wr(DP, 8'h01); rd(DP, v); chk("R11 no bank 9", v, 8'h00);
    chk("R11 act pins unchanged", dev_act, 9'h010);

    // R12 alternate base
    strap_alt = 1'b1;
    do_reset();
    wr(KP, 8'h55); wr(KP, 8'h55); chk("R12 primary ignored", cfg_mode, 0);
    wr(16'h0370, 8'h55); wr(16'h0370, 8'h55); chk("R12 alternate opens", cfg_mode, 1);
    wr(16'h0370, 8'h20); rd(16'h0371, v); chk("R12 alternate data", v, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule